// File: doc/BRIEF.md
# Program Fetch Memory Router

This block sits beside the fetch stage of an 8-bit controller core that has a 64 kB program space. For every fetch address it decides whether on-chip flash serves the fetch or the external memory bus does. It raises either an internal-select signal or an external-fetch request, and it drives an active-low program strobe that qualifies external fetches. The boundary between on-chip and off-chip space is not fixed. It comes from a 3-bit size code that software can lower, down to no on-chip memory at all, and later raise again. An external-only input pin overrides the size code and forces every fetch off-chip.

The size code is protected. A size write is accepted only inside a short window, and that window opens only after a two-byte key sequence is written to a key port on back-to-back cycles. The reset value of the code is the part's full on-chip size, set by a parameter. A write that asks for more than the part physically holds is clamped to that size. The decision is combinational from the stored code, so a new code applies to the first fetch after the write edge.

Top module: `progmem_route`

## Requirements
- R1: Size code c selects the on-chip range. c=0 means no on-chip memory. For c=1..7 the on-chip range is 0 up to (1024 << (c-1)) - 1, which gives tops of 03FFh, 07FFh, 0FFFh, 1FFFh, 3FFFh, 7FFFh and FFFFh.
- R2: After reset the size code equals parameter FULL_CODE. The default is 5, a 16 kB part with top 3FFFh.
- R3: A valid fetch at or below the selected top asserts `int_sel`. A valid fetch above the top asserts `ext_req`. Exactly one of the two is high during a valid fetch.
- R4: With code 0, every valid fetch at any of the 65536 addresses asserts `ext_req`.
- R5: While `ext_only_n` is low, every valid fetch asserts `ext_req`, whatever the code.
- R6: `prog_strobe_n` is low only in a cycle with a valid fetch routed externally. With `fetch_valid` low, `int_sel` and `ext_req` are both low and `prog_strobe_n` is high.
- R7: An accepted size write applies to the fetch in the cycle right after the write's clock edge.
- R8: A size write outside the unlock window leaves the code unchanged.
- R9: Writing key byte A5h and then key byte 5Ah on consecutive clock edges opens a window of 4 edges. The window starts at the edge after the 5Ah write, and size writes on those edges are accepted. A gap between the keys, the reverse order or any other byte leaves the register locked.
- R10: A size write above FULL_CODE stores FULL_CODE.
- R11: `size_rdata` returns the code in bits 2:0 and zero in bits 7:3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_we | input | 1 | Key byte write strobe |
| key_data | input | 8 | Key byte |
| size_we | input | 1 | Size code write strobe |
| size_wdata | input | 3 | Requested size code |
| size_rdata | output | 8 | Current size code, upper bits zero |
| fetch_valid | input | 1 | A fetch is presented this cycle |
| fetch_addr | input | 16 | Fetch address |
| ext_only_n | input | 1 | Low forces every fetch external |
| int_sel | output | 1 | Fetch served on-chip |
| ext_req | output | 1 | Fetch served by the external bus |
| prog_strobe_n | output | 1 | Active-low external program strobe |

## Verification
The hardest condition to reach is the edge of the unlock window. The bench has to land a size write on exactly the fourth edge after the second key, and again on the fifth. It also has to tell a rejected write from an accepted one that happens to store the same value. The stimulus runs the key sequence and then waits a counted number of idle cycles before the write. Each attempt requests a code different from the stored one, so readback and the fetch routing at the new boundary both show whether the write took effect.

// File: rtl/progmem_pkg.sv
package progmem_pkg;
  localparam int ADDR_W = 16;
  localparam int CODE_W = 3;
  localparam int SHIFT_BASE = 9;

  // Highest on-chip address for code c (c>0): 2^(c+9)-1, one bit wider than the address
  function automatic logic [ADDR_W:0] top_addr(input logic [CODE_W-1:0] code);
    logic [ADDR_W:0] one;
    one = (ADDR_W+1)'(1);
    return (one << (5'(code) + 5'(SHIFT_BASE))) - one;
  endfunction

  function automatic logic hits_onchip(input logic [CODE_W-1:0] code,
                                       input logic [ADDR_W-1:0] addr);
    return (code != '0) && ({1'b0, addr} <= top_addr(code));
  endfunction

  function automatic logic [CODE_W-1:0] clamp_code(input logic [CODE_W-1:0] req,
                                                   input logic [CODE_W-1:0] max);
    return (req > max) ? max : req;
  endfunction
endpackage

// File: rtl/pm_unlock.sv
module pm_unlock #(
  parameter logic [7:0] KEY_A   = 8'hA5,
  parameter logic [7:0] KEY_B   = 8'h5A,
  parameter int         WIN_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_we,
  input  logic [7:0] key_data,
  output logic       win_open
);
  localparam int CNT_W = $clog2(WIN_LEN + 1);

  logic             armed;
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      left_q <= '0;
    end else begin
      armed <= key_we && (key_data == KEY_A);
      if (key_we && (key_data == KEY_B) && armed)
        left_q <= CNT_W'(WIN_LEN);
      else if (left_q != '0)
        left_q <= left_q - CNT_W'(1);
    end
  end

  assign win_open = (left_q != '0);
endmodule

// File: rtl/pm_size_reg.sv
module pm_size_reg
  import progmem_pkg::*;
#(
  parameter int FULL_CODE = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_accept,
  input  logic [CODE_W-1:0] wdata,
  output logic [CODE_W-1:0] code
);
  localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(FULL_CODE);

  always_ff @(posedge clk) begin
    if (!rst_n)
      code <= MAX_CODE;
    else if (wr_accept)
      code <= clamp_code(wdata, MAX_CODE);
  end
endmodule

// File: rtl/pm_decode.sv
module pm_decode
  import progmem_pkg::*;
(
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              ext_only_n,
  input  logic [CODE_W-1:0] code,
  output logic              int_sel,
  output logic              ext_req,
  output logic              prog_strobe_n
);
  logic onchip_hit;

  always_comb begin
    onchip_hit    = ext_only_n && hits_onchip(code, fetch_addr);
    int_sel       = fetch_valid && onchip_hit;
    ext_req       = fetch_valid && !onchip_hit;
    prog_strobe_n = !(fetch_valid && !onchip_hit);
  end
endmodule

// File: rtl/progmem_route.sv
module progmem_route
  import progmem_pkg::*;
#(
  parameter int         FULL_CODE = 5,
  parameter logic [7:0] KEY_A     = 8'hA5,
  parameter logic [7:0] KEY_B     = 8'h5A,
  parameter int         WIN_LEN   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_we,
  input  logic [7:0]  key_data,
  input  logic        size_we,
  input  logic [2:0]  size_wdata,
  output logic [7:0]  size_rdata,
  input  logic        fetch_valid,
  input  logic [15:0] fetch_addr,
  input  logic        ext_only_n,
  output logic        int_sel,
  output logic        ext_req,
  output logic        prog_strobe_n
);
  logic              win_open;
  logic              wr_accept;
  logic [CODE_W-1:0] size_code;

  pm_unlock #(.KEY_A(KEY_A), .KEY_B(KEY_B), .WIN_LEN(WIN_LEN)) unlock_i (
    .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_data(key_data),
    .win_open(win_open)
  );

  assign wr_accept = size_we && win_open;

  pm_size_reg #(.FULL_CODE(FULL_CODE)) size_i (
    .clk(clk), .rst_n(rst_n), .wr_accept(wr_accept), .wdata(size_wdata),
    .code(size_code)
  );

  assign size_rdata = {{(8-CODE_W){1'b0}}, size_code};

  pm_decode dec_i (
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .ext_only_n(ext_only_n),
    .code(size_code), .int_sel(int_sel), .ext_req(ext_req),
    .prog_strobe_n(prog_strobe_n)
  );
endmodule

// File: rtl/progmem_route_chk.sv
module progmem_route_chk #(
  parameter int FULL_CODE = 5
) (
  input logic        clk,
  input logic        rst_n,
  input logic        fetch_valid,
  input logic        ext_only_n,
  input logic        int_sel,
  input logic        ext_req,
  input logic        prog_strobe_n,
  input logic        win_open,
  input logic        wr_accept,
  input logic [2:0]  size_code,
  input logic [2:0]  size_wdata,
  input logic [7:0]  size_rdata
);
  a_r3_one_route: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> (int_sel ^ ext_req));

  a_r4_zero_code: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && size_code == 3'd0) |-> ext_req);

  a_r5_pin_override: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !ext_only_n) |-> (ext_req && !int_sel));

  a_r6_strobe_qual: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_strobe_n |-> (fetch_valid && ext_req));

  a_r6_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |-> (!int_sel && !ext_req && prog_strobe_n));

  a_r8_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_accept |=> $stable(size_code));

  a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> (size_code == (($past(size_wdata) > 3'(FULL_CODE)) ? 3'(FULL_CODE) : $past(size_wdata))));

  a_r9_needs_window: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |-> win_open);

  a_r10_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    size_code <= 3'(FULL_CODE));

  a_r11_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    size_rdata[7:3] == 5'd0);
endmodule

bind progmem_route progmem_route_chk #(.FULL_CODE(FULL_CODE)) chk_i (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .ext_only_n(ext_only_n),
  .int_sel(int_sel), .ext_req(ext_req), .prog_strobe_n(prog_strobe_n),
  .win_open(win_open), .wr_accept(wr_accept), .size_code(size_code),
  .size_wdata(size_wdata), .size_rdata(size_rdata)
);

// File: tb/progmem_route_tb.sv
module progmem_route_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        key_we;
  logic [7:0]  key_data;
  logic        size_we;
  logic [2:0]  size_wdata;
  logic [7:0]  size_rdata;
  logic        fetch_valid;
  logic [15:0] fetch_addr;
  logic        ext_only_n;
  logic        int_sel, ext_req, prog_strobe_n;

  int checks = 0;
  int errors = 0;
  localparam int FULL = 5;

  always #5 clk = ~clk;

  progmem_route dut_i (
    .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_data(key_data),
    .size_we(size_we), .size_wdata(size_wdata), .size_rdata(size_rdata),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .ext_only_n(ext_only_n),
    .int_sel(int_sel), .ext_req(ext_req), .prog_strobe_n(prog_strobe_n)
  );

  // {addr, ext_only_n, fetch_valid, exp_int, exp_ext} at reset code 5 (top 3FFFh)
  localparam int NV = 8;
  localparam logic [19:0] VEC [NV] = '{
    {16'h0000, 1'b1, 1'b1, 1'b1, 1'b0},
    {16'h3FFF, 1'b1, 1'b1, 1'b1, 1'b0},
    {16'h4000, 1'b1, 1'b1, 1'b0, 1'b1},
    {16'hFFFF, 1'b1, 1'b1, 1'b0, 1'b1},
    {16'h1234, 1'b1, 1'b1, 1'b1, 1'b0},
    {16'h0000, 1'b0, 1'b1, 1'b0, 1'b1},
    {16'h3FFF, 1'b0, 1'b1, 1'b0, 1'b1},
    {16'h1234, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  function automatic bit ref_onchip(int code, int addr);
    if (code == 0) return 1'b0;
    return addr < (1024 * (1 << (code - 1)));
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic fetch_check(string req, int code, logic [15:0] a, logic pin);
    bit on;
    on = pin && ref_onchip(code, int'(a));
    fetch_valid = 1'b1; fetch_addr = a; ext_only_n = pin;
    #1;
    check(req, "int_sel", int'(int_sel), int'(on));
    check(req, "ext_req", int'(ext_req), int'(!on));
    check(req, "strobe_n", int'(prog_strobe_n), int'(on));
    fetch_valid = 1'b0; ext_only_n = 1'b1;
  endtask

  task automatic key(logic [7:0] b);
    @(negedge clk); key_we = 1'b1; key_data = b;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); key_we = 1'b0; size_we = 1'b0;
    end
  endtask

  task automatic size_write(logic [2:0] v);
    @(negedge clk); key_we = 1'b0; size_we = 1'b1; size_wdata = v;
    @(negedge clk); size_we = 1'b0;
  endtask

  task automatic unlocked_write(logic [2:0] v, int gap);
    key(8'hA5); key(8'h5A);
    if (gap > 0) idle(gap);
    size_write(v);
  endtask

  initial begin
    #1500000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cur;
    rst_n = 1'b0; key_we = 1'b0; key_data = 8'h00; size_we = 1'b0;
    size_wdata = 3'd0; fetch_valid = 1'b0; fetch_addr = 16'h0; ext_only_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R2", "reset code", int'(size_rdata), FULL);
    check("R6", "idle int_sel", int'(int_sel), 0);
    check("R6", "idle strobe_n", int'(prog_strobe_n), 1);

    // Table walk at the reset code: R3, R5, R6
    for (int i = 0; i < NV; i++) begin
      fetch_valid = VEC[i][2]; fetch_addr = VEC[i][19:4]; ext_only_n = VEC[i][3];
      #1;
      check("R3", "vec int_sel", int'(int_sel), int'(VEC[i][1]));
      check("R5", "vec ext_req", int'(ext_req), int'(VEC[i][0]));
      check("R6", "vec strobe_n", int'(prog_strobe_n), int'(!VEC[i][0]));
      @(negedge clk);
    end
    fetch_valid = 1'b0; ext_only_n = 1'b1;

    // Every code: clamp, readback and boundary (R1, R4, R7, R10, R11)
    for (int c = 0; c < 8; c++) begin
      cur = (c > FULL) ? FULL : c;
      unlocked_write(3'(c), 0);
      #1;
      check(c > FULL ? "R10" : "R11", "readback", int'(size_rdata), cur);
      if (cur == 0) begin
        fetch_check("R4", 0, 16'h0000, 1'b1);
        fetch_check("R4", 0, 16'hFFFF, 1'b1);
      end else begin
        fetch_check("R1", cur, 16'((1024 << (cur - 1)) - 1), 1'b1);
        fetch_check("R1", cur, 16'(1024 << (cur - 1)), 1'b1);
      end
      idle(5);
    end

    // R7: the fetch in the cycle right after the write edge sees the new code
    unlocked_write(3'd1, 0);
    // size_write returns at the negedge after the write edge
    fetch_check("R7", 1, 16'h0400, 1'b1);
    idle(5);

    // R8: write without unlock is ignored
    size_write(3'd3);
    #1; check("R8", "no unlock", int'(size_rdata), 1);
    fetch_check("R8", 1, 16'h0400, 1'b1);

    // R9: reverse key order
    key(8'h5A); key(8'hA5); size_write(3'd4);
    #1; check("R9", "reverse order", int'(size_rdata), 1);
    idle(5);
    // R9: gap between keys
    key(8'hA5); idle(1); key(8'h5A); size_write(3'd4);
    #1; check("R9", "gap keys", int'(size_rdata), 1);
    idle(5);
    // R9: wrong byte
    key(8'hA5); key(8'h5B); size_write(3'd4);
    #1; check("R9", "wrong byte", int'(size_rdata), 1);
    idle(5);
    // R9: last edge of window (3 idle, write on 4th edge) accepted
    unlocked_write(3'd2, 3);
    #1; check("R9", "window edge 4", int'(size_rdata), 2);
    idle(5);
    // R9: one edge past the window rejected
    unlocked_write(3'd3, 4);
    #1; check("R9", "window edge 5", int'(size_rdata), 2);
    fetch_check("R9", 2, 16'h0800, 1'b1);

    // R5 with code 0 region reversed: pin low at an on-chip address
    fetch_check("R5", 2, 16'h0000, 1'b0);

    // Reset restores full code (R2)
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; #1;
    check("R2", "re-reset code", int'(size_rdata), FULL);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule